// File: doc/BRIEF.md
# Separable 8x8 Forward DCT Engine

This block computes the forward two-dimensional discrete cosine transform of one 8x8 block of 8-bit single-component samples. It takes in 64 samples, transforms every row with a direct 8-point matrix product, parks the row results in a transpose store, and then transforms every column the same way. The 64 results leave in raster order, each one rounded and scaled back to a 12-bit signed value. A single multiply-accumulate unit serves both passes, one product per cycle, so a block costs 1024 multiply cycles.

Samples arrive on a valid/ready stream and results leave on another. The input side is ready only while a block is being collected. Once the 64th sample has been taken, the input stays stalled until the sink has accepted the last result of that block. The output side holds each result, unchanged, for as long as the sink withholds ready. A stalled sink therefore freezes the column pass and nothing is lost. A new block begins only after the previous one has fully drained.

Top module: `dct8x8_engine`

## Requirements
- R1: Each input sample is an unsigned 8-bit value; the engine works on the sample minus 128 as a signed value.
- R2: The coefficient for frequency u and position x (both 0..7) is round(2048 * a(u) * cos((2x+1) * u * pi / 16)), with a(0) = sqrt(1/8) and a(u) = 1/2 for u > 0. This is a signed 12-bit value with 11 fractional bits.
- R3: The row pass forms R[y][u] = sum over x of coef(u,x) * s[y][x] at full precision, where s[y][x] is the level-shifted sample at input position y*8+x. Each of the 64 row results is stored once, after its eight terms are summed.
- R4: The column pass forms F[v][u] = sum over y of coef(v,y) * R[y][u]. The output is (F + 2^21) shifted right arithmetically by 22 and saturated to [-2048, 2047]. It appears on out_data in two's complement, in raster order v*8+u.
- R5: in_ready is high only while a block is being collected. Exactly 64 samples are taken per block, in raster order y*8+x. in_ready is low from the cycle after the 64th accepted sample until the last result is accepted, and it is high again in the next cycle. in_valid has no effect while in_ready is low.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R7: With out_ready held high, the first result is accepted 521 cycles after the last sample is accepted. Each later result of the block is accepted 9 cycles after the one before it.
- R8: During and just after reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready; high only while collecting a block |
| in_data | input | 8 | Unsigned sample, raster order within the block |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready from the sink |
| out_data | output | 12 | Signed transform coefficient, raster order |

## Verification
The assertions assume that reset is asserted before the first transfer. They place no limit on how long the sink may hold out_ready low, and they assume nothing about in_valid while the engine is busy. The stimulus stays within these bounds. It asserts reset first, keeps in_valid high across busy periods so that ignored offers are exercised, and inserts random input bubbles. It drives out_ready either constantly high, for the timing checks, or with a pseudo-random stall pattern. All samples are generated as 8-bit values, so the level-shifted operands always lie in [-128, 127].

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int N         = 8;
  localparam int IDX_W     = $clog2(N);
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 11;

  typedef enum logic [1:0] {ST_LOAD, ST_ROW, ST_COL, ST_EMIT} dct_state_e;

  // quarter-wave cosine magnitudes scaled by 2^10 (k = 0..8 in steps of pi/16)
  function automatic int cos_mag(input int k);
    case (k)
      0: return 1024;
      1: return 1004;
      2: return 946;
      3: return 851;
      4: return 724;
      5: return 569;
      6: return 392;
      7: return 200;
      default: return 0;
    endcase
  endfunction

  function automatic logic signed [COEF_W-1:0] dct_coef(input int u, input int x);
    int  ph;
    bit  neg;
    int  mag;
    if (u == 0) return COEF_W'(724);
    ph = ((2 * x + 1) * u) % 32;
    if (ph > 16) ph = 32 - ph;
    neg = (ph > 8);
    if (neg) ph = 16 - ph;
    mag = cos_mag(ph);
    return neg ? COEF_W'(-mag) : COEF_W'(mag);
  endfunction
endpackage

// File: rtl/dct_coef_rom.sv
module dct_coef_rom
  import dct_pkg::*;
(
  input  logic [IDX_W-1:0]         freq,
  input  logic [IDX_W-1:0]         pos,
  output logic signed [COEF_W-1:0] coef
);
  logic signed [COEF_W-1:0] table_q [N*N];

  for (genvar gu = 0; gu < N; gu++) begin : g_freq
    for (genvar gx = 0; gx < N; gx++) begin : g_pos
      assign table_q[gu*N + gx] = dct_coef(gu, gx);
    end
  end

  assign coef = table_q[{freq, pos}];
endmodule

// File: rtl/dct_mac.sv
module dct_mac #(
  parameter int A_W = 23,
  parameter int B_W = 12,
  parameter int S_W = 38
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  first,
  input  logic signed [A_W-1:0] opa,
  input  logic signed [B_W-1:0] opb,
  output logic signed [S_W-1:0] sum
);
  localparam int P_W = A_W + B_W;

  logic signed [P_W-1:0] prod;
  logic signed [S_W-1:0] prod_ext;
  logic signed [S_W-1:0] acc_q;

  assign prod     = opa * opb;
  assign prod_ext = {{(S_W-P_W){prod[P_W-1]}}, prod};
  assign sum      = (first ? '0 : acc_q) + prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= sum;
  end
endmodule

// File: rtl/dct_scale.sv
module dct_scale #(
  parameter int IN_W  = 38,
  parameter int SHIFT = 22,
  parameter int OUT_W = 12
) (
  input  logic signed [IN_W-1:0]  acc,
  output logic signed [OUT_W-1:0] res
);
  localparam int Q_W = IN_W - SHIFT;
  localparam logic signed [Q_W-1:0] HI = Q_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [Q_W-1:0] LO = Q_W'(-(2 ** (OUT_W - 1)));
  localparam logic signed [IN_W-1:0] HALF = IN_W'(1) << (SHIFT - 1);

  logic signed [IN_W-1:0] rounded;
  logic signed [Q_W-1:0]  q;

  assign rounded = acc + HALF;
  assign q       = rounded[IN_W-1:SHIFT];

  always_comb begin
    if (q > HI)      res = HI[OUT_W-1:0];
    else if (q < LO) res = LO[OUT_W-1:0];
    else             res = q[OUT_W-1:0];
  end
endmodule

// File: rtl/dct8x8_engine.sv
module dct8x8_engine
  import dct_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int OUT_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SAMPLE_W-1:0]     in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int NPIX   = N * N;
  localparam int ADDR_W = 2 * IDX_W;
  localparam int OPW    = SAMPLE_W + COEF_W + IDX_W;
  localparam int ACC_W  = OPW + COEF_W + IDX_W;
  localparam int SHIFT  = 2 * COEF_FRAC;
  localparam logic [ADDR_W-1:0] LAST_PIX = ADDR_W'(NPIX - 1);
  localparam logic [IDX_W-1:0]  LAST_K   = IDX_W'(N - 1);

  dct_state_e state;
  logic [ADDR_W-1:0] lcnt, ocnt;
  logic [IDX_W-1:0]  kcnt;

  logic signed [SAMPLE_W-1:0] sbuf [NPIX];
  logic signed [OPW-1:0]      tram [NPIX];

  logic                       in_fire, row_pass, mac_en, last_k;
  logic signed [SAMPLE_W-1:0] shifted, samp_rd;
  logic [ADDR_W-1:0]          rd_addr;
  logic [IDX_W-1:0]           coef_freq;
  logic signed [COEF_W-1:0]   coef;
  logic signed [OPW-1:0]      operand;
  logic signed [ACC_W-1:0]    acc_sum;
  logic signed [OUT_W-1:0]    scaled;

  assign in_ready = (state == ST_LOAD);
  assign in_fire  = in_valid && in_ready;
  assign row_pass = (state == ST_ROW);
  assign mac_en   = row_pass || (state == ST_COL);
  assign last_k   = (kcnt == LAST_K);

  // level shift by half range: invert the sample MSB
  assign shifted = {~in_data[SAMPLE_W-1], in_data[SAMPLE_W-2:0]};

  // row pass walks samples along a row; column pass walks the transpose store down a column
  assign rd_addr   = row_pass ? {ocnt[ADDR_W-1:IDX_W], kcnt} : {kcnt, ocnt[IDX_W-1:0]};
  assign coef_freq = row_pass ? ocnt[IDX_W-1:0] : ocnt[ADDR_W-1:IDX_W];
  assign samp_rd   = sbuf[rd_addr];
  assign operand   = row_pass ? {{(OPW-SAMPLE_W){samp_rd[SAMPLE_W-1]}}, samp_rd}
                              : tram[rd_addr];

  dct_coef_rom u_rom (
    .freq (coef_freq),
    .pos  (kcnt),
    .coef (coef)
  );

  dct_mac #(.A_W(OPW), .B_W(COEF_W), .S_W(ACC_W)) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mac_en),
    .first (kcnt == '0),
    .opa   (operand),
    .opb   (coef),
    .sum   (acc_sum)
  );

  dct_scale #(.IN_W(ACC_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_scale (
    .acc (acc_sum),
    .res (scaled)
  );

  always_ff @(posedge clk) begin
    if (in_fire)              sbuf[lcnt] <= shifted;
    if (row_pass && last_k)   tram[ocnt] <= acc_sum[OPW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_LOAD;
      lcnt      <= '0;
      ocnt      <= '0;
      kcnt      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      unique case (state)
        ST_LOAD: if (in_fire) begin
          lcnt <= lcnt + 1'b1;
          if (lcnt == LAST_PIX) begin
            state <= ST_ROW;
            ocnt  <= '0;
            kcnt  <= '0;
          end
        end
        ST_ROW: begin
          kcnt <= kcnt + 1'b1;
          if (last_k) begin
            ocnt <= ocnt + 1'b1;
            if (ocnt == LAST_PIX) state <= ST_COL;
          end
        end
        ST_COL: begin
          kcnt <= kcnt + 1'b1;
          if (last_k) begin
            out_data  <= scaled;
            out_valid <= 1'b1;
            state     <= ST_EMIT;
          end
        end
        ST_EMIT: if (out_ready) begin
          out_valid <= 1'b0;
          ocnt      <= ocnt + 1'b1;
          state     <= (ocnt == LAST_PIX) ? ST_LOAD : ST_COL;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  assert_ready_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_load_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && lcnt == LAST_PIX) |=> (!in_ready && !out_valid));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && ocnt == LAST_PIX) |=> (in_ready && !out_valid));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/dct8x8_engine_tb_top.sv
`timescale 1ns/1ps
module dct8x8_engine_tb_top;
  localparam int OUT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic [7:0]              in_data = '0;
  logic                    out_valid;
  logic                    out_ready = 1'b0;
  logic signed [OUT_W-1:0] out_data;

  dct8x8_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int          nvec = 0, nfail = 0;
  int          exp_q[$];
  int          K[8][8];
  int          blk[64];
  longint      cyc = 0, last_in_cyc = 0, prev_out_cyc = 0;
  bit          timing_on = 1, rdy_random = 0, gaps = 0, done = 0;
  bit          chk_release = 0, stall_prev = 0;
  int          out_idx = 0;
  logic signed [OUT_W-1:0] held = '0;
  logic [31:0] rs_drv = 32'h1234_5678, rs_mon = 32'h0BAD_F00D;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R2: coefficients from the cosine definition, computed in floating point
  task automatic build_coefs();
    for (int u = 0; u < 8; u++)
      for (int x = 0; x < 8; x++) begin
        real a, v;
        a = (u == 0) ? $sqrt(0.125) : 0.5;
        v = 2048.0 * a * $cos((2 * x + 1) * u * 3.14159265358979 / 16.0);
        K[u][x] = (v >= 0.0) ? int'($floor(v + 0.5)) : -int'($floor(-v + 0.5));
      end
  endtask

  // R1 R3 R4: reference transform of blk
  task automatic push_expected();
    longint r[8][8];
    for (int y = 0; y < 8; y++)
      for (int u = 0; u < 8; u++) begin
        longint acc = 0;
        for (int x = 0; x < 8; x++) acc += longint'(K[u][x]) * longint'(blk[y*8+x] - 128);
        r[y][u] = acc;
      end
    for (int v = 0; v < 8; v++)
      for (int u = 0; u < 8; u++) begin
        longint f = 0, q;
        for (int y = 0; y < 8; y++) f += longint'(K[v][y]) * r[y][u];
        q = (f + (64'sd1 <<< 21)) >>> 22;
        if (q > 2047) q = 2047;
        if (q < -2048) q = -2048;
        exp_q.push_back(int'(q));
      end
  endtask

  task automatic send_block();
    push_expected();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (gaps) begin
        rs_drv = rs_drv * 32'd1664525 + 32'd1013904223;
        if (rs_drv[28:27] == 2'b00) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      in_data  = blk[i][7:0];
      while (!in_ready) @(negedge clk);
      last_in_cyc = cyc + 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic fill_random();
    for (int i = 0; i < 64; i++) begin
      rs_drv = rs_drv * 32'd1664525 + 32'd1013904223;
      blk[i] = int'(rs_drv[23:16]);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (chk_release) begin
        check(in_ready === 1'b1, "R5 ready after last result", longint'(in_ready), 1);
        chk_release = 0;
      end
      if (stall_prev) begin
        check(out_valid === 1'b1, "R6 valid held", longint'(out_valid), 1);
        check(out_data == held, "R6 data held", longint'(out_data), longint'(held));
      end
      if (rdy_random) begin
        rs_mon = rs_mon * 32'd22695477 + 32'd1;
        out_ready = rs_mon[30] | rs_mon[29];
      end else begin
        out_ready = 1'b1;
      end
      stall_prev = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected result", longint'(out_data), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(out_data) == e, "R1/R2/R3/R4 result", longint'(out_data), longint'(e));
        end
        if (out_idx == 0)
          check(in_ready === 1'b0, "R5 input stalled while busy", longint'(in_ready), 0);
        if (timing_on) begin
          if (out_idx == 0)
            check(cyc + 1 - last_in_cyc == 521, "R7 first latency", cyc + 1 - last_in_cyc, 521);
          else
            check(cyc + 1 - prev_out_cyc == 9, "R7 result spacing", cyc + 1 - prev_out_cyc, 9);
        end
        prev_out_cyc = cyc + 1;
        if (out_idx == 63) chk_release = 1;
        out_idx = (out_idx + 1) % 64;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++;
      nfail++;
      $display("FAIL watchdog expired, %0d results outstanding", exp_q.size());
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    build_coefs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready === 1'b1, "R8 in_ready in reset", longint'(in_ready), 1);
    check(out_valid === 1'b0, "R8 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R8 in_ready after reset", longint'(in_ready), 1);
    check(out_valid === 1'b0, "R8 out_valid after reset", longint'(out_valid), 0);

    // phase 1: sink always ready, timing checked (R7)
    for (int i = 0; i < 64; i++) blk[i] = 128;
    send_block();
    for (int i = 0; i < 64; i++) blk[i] = 255;
    send_block();
    for (int i = 0; i < 64; i++) blk[i] = 0;
    send_block();
    for (int i = 0; i < 64; i++) blk[i] = (((i / 8) + (i % 8)) % 2 == 0) ? 0 : 255;
    send_block();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    // phase 2: random sink stalls and input bubbles (R5 R6)
    timing_on  = 0;
    rdy_random = 1;
    gaps       = 1;
    for (int i = 0; i < 64; i++) blk[i] = (i % 8) * 32;
    send_block();
    for (int i = 0; i < 64; i++) blk[i] = (i / 8) * 36;
    send_block();
    for (int i = 0; i < 64; i++) blk[i] = (i == 29) ? 255 : 128;
    send_block();
    fill_random();
    send_block();
    fill_random();
    send_block();
    while (exp_q.size() != 0 && !done) @(negedge clk);
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule